// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Status Unit

This block holds the receive and transmit byte queues of a single UART channel. A receiver core hands it incoming bytes and a transmitter core pulls bytes from it. Software writes transmit bytes into it and reads received bytes out of it through holding-register strobes. It reports how full each queue is in a packed status word and in a short transmit/receive status word. It pulses interrupt requests and drives block-DMA request levels, according to a 4-bit direction-mode control field.

One enable bit chooses between two paths. With the bit set, each direction has a 16-deep queue. With the bit clear, each direction behaves as a single holding register. Writing the enable bit empties both directions. The block has no baud generator, no serial framing, no modem lines and no DMA engine. It only exposes the request levels that such an engine would watch.

Top module: `uart_fifo_stat`

## Requirements
- R1: After reset the queue status word reads 0, the transmit/receive status word reads 0x6, and `rx_irq`, `tx_irq`, `tx_out_valid` and both DMA requests are low.
- R2: With queues enabled, a pulse on `rxh_rd` removes the oldest received byte and shows it on `rxh_data` from the next cycle on, so bytes come out in arrival order.
- R3: With queues enabled, the status word has the receive count in bits 3:0, the transmit count in bits 7:4, receive-full in bit 8 and transmit-full in bit 9. With queues disabled it reads 0.
- R4: A queue holding 16 bytes shows count 15 with its full bit set: 0x10F for receive and 0x2F0 for transmit. Removing one byte from a full receive queue gives 0x00F.
- R5: A byte offered to a full queue is dropped. A read of an empty receive queue leaves `rxh_data` and the counts unchanged.
- R6: With queues disabled, each direction holds one byte. Bit 0 of the transmit/receive status word is the receive data-ready flag, and a received byte is accepted only while that flag is clear.
- R7: The control field is {transmit mode[3:2], receive mode[1:0]}. Mode 00 disables a direction: received bytes are ignored, and `tx_out_valid` stays low.
- R8: With receive mode 01, every accepted received byte yields a one-cycle `rx_irq` pulse in the cycle after it is accepted.
- R9: With transmit mode 01, every byte taken by the transmitter (`tx_take` while `tx_out_valid`) yields a one-cycle `tx_irq` pulse in the next cycle.
- R10: Mode 10 selects block-DMA channel 0 and mode 11 selects channel 1. When a direction's mode is DMA on this instance's channel `CH`, `rx_dma_req` is high while received data is waiting, and `tx_dma_req` is high while the transmit side has room.
- R11: A write to the queue-enable bit empties both directions.
- R12: Bits 2 and 1 of the transmit/receive status word are both high exactly when the transmit side is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the mode field |
| ctl_wdata | input | 4 | {transmit mode, receive mode} |
| fen_we | input | 1 | Write strobe for the queue-enable bit |
| fen_wdata | input | 1 | Queue-enable value |
| rx_in_valid | input | 1 | Receiver core offers a byte |
| rx_in_byte | input | W | Byte from receiver core |
| rxh_rd | input | 1 | Read strobe of receive holding register |
| rxh_data | output | W | Last byte read from the receive side |
| txh_wr | input | 1 | Write strobe of transmit holding register |
| txh_wdata | input | W | Byte written for transmission |
| tx_out_valid | output | 1 | A byte is offered to the transmitter core |
| tx_out_byte | output | W | Oldest transmit byte |
| tx_take | input | 1 | Transmitter core takes the offered byte |
| fifo_stat | output | 2*log2(DEPTH)+2 | Packed queue status word |
| trx_stat | output | 3 | {tx empty, tx empty, rx data ready} |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_dma_req | output | 1 | Receive DMA request level |
| tx_dma_req | output | 1 | Transmit DMA request level |

## Verification
Directed sequences fill each queue to exactly 16, offer a seventeenth byte, and drain past empty. These separate correct saturation of the count field from wrap-around, and a dropped byte from an overwrite. A single-register pass shows whether the data-ready flag really gates the receiver. Mode sweeps through 00, 01, 10 and 11 show whether interrupts and DMA requests follow the right direction and channel. A long seeded random mix of simultaneous push, pop, take and mode changes exercises same-cycle push/pop counting against a queue model in the bench.

// File: rtl/uart_fifo_stat.sv
module uart_fifo_stat #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter bit CH    = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_we,
  input  logic [3:0]                   ctl_wdata,
  input  logic                         fen_we,
  input  logic                         fen_wdata,
  input  logic                         rx_in_valid,
  input  logic [W-1:0]                 rx_in_byte,
  input  logic                         rxh_rd,
  output logic [W-1:0]                 rxh_data,
  input  logic                         txh_wr,
  input  logic [W-1:0]                 txh_wdata,
  output logic                         tx_out_valid,
  output logic [W-1:0]                 tx_out_byte,
  input  logic                         tx_take,
  output logic [2*$clog2(DEPTH)+1:0]   fifo_stat,
  output logic [2:0]                   trx_stat,
  output logic                         rx_irq,
  output logic                         tx_irq,
  output logic                         rx_dma_req,
  output logic                         tx_dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          fen;
  logic [1:0]    rxm, txm;
  logic [W-1:0]  rmem [DEPTH];
  logic [W-1:0]  tmem [DEPTH];
  logic [AW-1:0] rwp, rrp, twp, trp;
  logic [CW-1:0] rcnt, tcnt;

  wire [CW-1:0] cap   = fen ? CW'(DEPTH) : CW'(1);
  wire          rpush = !fen_we && rx_in_valid && rxm != 2'b00 && rcnt < cap;
  wire          rpop  = !fen_we && rxh_rd && rcnt != '0;
  wire          tpush = !fen_we && txh_wr && tcnt < cap;
  wire          tpop  = !fen_we && tx_take && tx_out_valid;

  assign tx_out_valid = txm != 2'b00 && tcnt != '0;
  assign tx_out_byte  = tmem[trp];

  wire [AW-1:0] rfield = rcnt[AW] ? '1 : rcnt[AW-1:0];
  wire [AW-1:0] tfield = tcnt[AW] ? '1 : tcnt[AW-1:0];
  assign fifo_stat  = fen ? {tcnt[AW], rcnt[AW], tfield, rfield} : '0;
  assign trx_stat   = {tcnt == '0, tcnt == '0, rcnt != '0};
  assign rx_dma_req = rxm == {1'b1, CH} && rcnt != '0;
  assign tx_dma_req = txm == {1'b1, CH} && tcnt < cap;

  always_ff @(posedge clk) begin
    if (rpush) rmem[rwp] <= rx_in_byte;
    if (tpush) tmem[twp] <= txh_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fen <= 1'b0; rxm <= 2'b00; txm <= 2'b00;
      rwp <= '0; rrp <= '0; twp <= '0; trp <= '0;
      rcnt <= '0; tcnt <= '0;
      rxh_data <= '0; rx_irq <= 1'b0; tx_irq <= 1'b0;
    end else begin
      if (ctl_we) {txm, rxm} <= ctl_wdata;
      rx_irq <= rpush && rxm == 2'b01;
      tx_irq <= tpop && txm == 2'b01;
      if (rpop) rxh_data <= rmem[rrp];
      if (fen_we) begin
        fen <= fen_wdata;
        rwp <= '0; rrp <= '0; twp <= '0; trp <= '0;
        rcnt <= '0; tcnt <= '0;
      end else begin
        if (rpush) rwp <= rwp + 1'b1;
        if (rpop)  rrp <= rrp + 1'b1;
        if (tpush) twp <= twp + 1'b1;
        if (tpop)  trp <= trp + 1'b1;
        rcnt <= rcnt + CW'(rpush) - CW'(rpop);
        tcnt <= tcnt + CW'(tpush) - CW'(tpop);
      end
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= cap && tcnt <= cap);
  // R6
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fen |-> rcnt <= CW'(1) && tcnt <= CW'(1));
  // R7
  tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txm == 2'b00 |-> !tx_out_valid);
  // R8
  rx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(rx_in_valid) && $past(rxm) == 2'b01);
  // R9
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(tx_take) && $past(txm) == 2'b01);
endmodule

// File: tb/tb_uart_fifo_stat.sv
module tb_uart_fifo_stat;
  localparam int PER = 10;
  localparam int D = 16;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, fen_we = 0, fen_wdata = 0;
  logic [3:0] ctl_wdata = 0;
  logic rx_in_valid = 0, rxh_rd = 0, txh_wr = 0, tx_take = 0;
  logic [7:0] rx_in_byte = 0, txh_wdata = 0;
  logic [7:0] rxh_data, tx_out_byte;
  logic tx_out_valid, rx_irq, tx_irq, rx_dma_req, tx_dma_req;
  logic [9:0] fifo_stat;
  logic [2:0] trx_stat;

  always #(PER/2) clk = ~clk;

  uart_fifo_stat dut (.clk, .rst_n, .ctl_we, .ctl_wdata, .fen_we, .fen_wdata,
    .rx_in_valid, .rx_in_byte, .rxh_rd, .rxh_data, .txh_wr, .txh_wdata,
    .tx_out_valid, .tx_out_byte, .tx_take, .fifo_stat, .trx_stat,
    .rx_irq, .tx_irq, .rx_dma_req, .tx_dma_req);

  int nchk = 0, nfail = 0;
  logic [7:0] rq[$], tq[$];
  logic m_fen = 0;
  logic [1:0] m_rxm = 0, m_txm = 0;
  logic [7:0] m_rxh = 0;
  logic e_rirq = 0, e_tirq = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sat(int c);
    return (c >= D) ? 4'hF : 4'(c);
  endfunction

  function automatic logic [9:0] exp_stat();
    if (!m_fen) return 10'h0;
    return {tq.size() == D, rq.size() == D, sat(tq.size()), sat(rq.size())};
  endfunction

  function automatic int cap();
    return m_fen ? D : 1;
  endfunction

  task automatic compare();
    check("R3 fifo_stat", 32'(fifo_stat), 32'(exp_stat()));
    check("R12 trx_stat", 32'(trx_stat), 32'({tq.size() == 0, tq.size() == 0, rq.size() != 0}));
    check("R2 rxh_data", 32'(rxh_data), 32'(m_rxh));
    check("R8 rx_irq", 32'(rx_irq), 32'(e_rirq));
    check("R9 tx_irq", 32'(tx_irq), 32'(e_tirq));
    check("R7 tx_out_valid", 32'(tx_out_valid), 32'(m_txm != 0 && tq.size() != 0));
    if (tq.size() != 0) check("R2 tx_out_byte", 32'(tx_out_byte), 32'(tq[0]));
    check("R10 rx_dma_req", 32'(rx_dma_req), 32'(m_rxm == 2'b10 && rq.size() != 0));
    check("R10 tx_dma_req", 32'(tx_dma_req), 32'(m_txm == 2'b10 && tq.size() < cap()));
  endtask

  task automatic step(logic rv, logic [7:0] rb, logic rd, logic tw, logic [7:0] td, logic tk);
    logic rpush, rpop, tpush, tpop;
    rx_in_valid = rv; rx_in_byte = rb; rxh_rd = rd;
    txh_wr = tw; txh_wdata = td; tx_take = tk;
    @(posedge clk);
    rpush = rv && m_rxm != 0 && rq.size() < cap();
    rpop  = rd && rq.size() != 0;
    tpush = tw && tq.size() < cap();
    tpop  = tk && m_txm != 0 && tq.size() != 0;
    e_rirq = rpush && m_rxm == 2'b01;
    e_tirq = tpop && m_txm == 2'b01;
    if (rpop) m_rxh = rq.pop_front();
    if (rpush) rq.push_back(rb);
    if (tpop) void'(tq.pop_front());
    if (tpush) tq.push_back(td);
    #1;
    rx_in_valid = 0; rxh_rd = 0; txh_wr = 0; tx_take = 0;
    compare();
  endtask

  task automatic wr_ctl(logic [3:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(posedge clk);
    {m_txm, m_rxm} = v; e_rirq = 0; e_tirq = 0;
    #1; ctl_we = 0; compare();
  endtask

  task automatic wr_fen(logic v);
    fen_we = 1; fen_wdata = v;
    @(posedge clk);
    m_fen = v; rq.delete(); tq.delete(); e_rirq = 0; e_tirq = 0;
    #1; fen_we = 0; compare();
  endtask

  initial begin
    #(PER * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    check("R1 fifo_stat", 32'(fifo_stat), 0);
    check("R1 trx_stat", 32'(trx_stat), 32'h6);
    check("R1 outputs", 32'({rx_irq, tx_irq, tx_out_valid, rx_dma_req, tx_dma_req}), 0);

    wr_ctl(4'b0101);
    wr_fen(1);
    for (int i = 0; i < 16; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 0);
    check("R4 rx full", 32'(fifo_stat), 32'h10F);
    step(1, 8'hEE, 0, 0, 0, 0);
    check("R5 push into full", 32'(fifo_stat), 32'h10F);
    check("R5 no irq on drop", 32'(rx_irq), 0);
    step(0, 0, 1, 0, 0, 0);
    check("R4 pop from full", 32'(fifo_stat), 32'h00F);
    check("R2 oldest", 32'(rxh_data), 32'hA0);
    for (int i = 1; i < 16; i++) step(0, 0, 1, 0, 0, 0);
    check("R2 last byte", 32'(rxh_data), 32'hAF);
    step(0, 0, 1, 0, 0, 0);
    check("R5 pop empty data", 32'(rxh_data), 32'hAF);
    check("R5 pop empty count", 32'(fifo_stat), 0);

    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 8'h30 + 8'(i), 0);
    check("R4 tx full", 32'(fifo_stat), 32'h2F0);
    check("R12 tx not empty", 32'(trx_stat[2:1]), 0);
    step(0, 0, 0, 0, 0, 1);
    check("R9 tx irq pulse", 32'(tx_irq), 1);
    step(0, 0, 0, 0, 0, 0);
    check("R9 pulse one cycle", 32'(tx_irq), 0);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 0, 1);
    check("R12 tx empty", 32'(trx_stat[2:1]), 3);

    wr_fen(0);
    step(1, 8'h11, 0, 0, 0, 0);
    check("R8 rx irq pulse", 32'(rx_irq), 1);
    step(1, 8'h22, 0, 0, 0, 0);
    check("R6 ready flag", 32'(trx_stat[0]), 1);
    check("R6 stat zero", 32'(fifo_stat), 0);
    step(0, 0, 1, 0, 0, 0);
    check("R6 held byte", 32'(rxh_data), 32'h11);
    check("R6 ready cleared", 32'(trx_stat[0]), 0);

    wr_ctl(4'b0000);
    step(1, 8'h55, 0, 1, 8'h66, 0);
    check("R7 rx ignored", 32'(trx_stat[0]), 0);
    check("R7 tx held", 32'(tx_out_valid), 0);
    step(0, 0, 0, 0, 0, 1);
    check("R7 take ignored", 32'(trx_stat[2:1]), 0);

    wr_fen(1);
    wr_ctl(4'b1010);
    step(1, 8'h77, 0, 0, 0, 0);
    check("R10 rx dma", 32'(rx_dma_req), 1);
    check("R10 tx dma", 32'(tx_dma_req), 1);
    wr_ctl(4'b1111);
    check("R10 other channel", 32'({rx_dma_req, tx_dma_req}), 0);
    step(0, 0, 0, 1, 8'h12, 0);
    wr_fen(1);
    check("R11 emptied", 32'(fifo_stat), 0);
    check("R11 trx", 32'(trx_stat), 32'h6);

    for (int c = 0; c < 4000; c++) begin
      if (c % 97 == 0) wr_ctl(4'($urandom));
      else if (c % 613 == 0) wr_fen(1'($urandom));
      else step(1'($urandom), 8'($urandom), ($urandom % 3) == 0,
                1'($urandom), 8'($urandom), ($urandom % 3) == 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule